// File: doc/BRIEF.md
# Soft-Decision Threshold Demapper for Gray PSK/QAM

This block turns received complex samples into per-bit log-likelihood ratios for Gray-coded BPSK, QPSK, 8-PSK, 16-QAM and 64-QAM. It computes no distances. Each bit's soft value is a piecewise-linear function of the in-phase or quadrature component, or of their magnitudes. That value is multiplied by a noise-dependent gain, rounded and clipped to a short signed word. Two soft bits leave the block per clock, each with a valid flag and the index of the bit it belongs to.

Samples arrive with a valid/ready handshake. The sample, the gain and the modulation code are all captured together when a sample is accepted. A symbol that needs more than two soft bits holds off the next sample until its last pair is being emitted. The sample is fixed point, with one constellation unit equal to 16 LSBs. The threshold constants 2 and 4 are therefore 32 and 64 at that scale.

Top module: `llr_demapper`

## Requirements
- R1: After reset, `symReady` is 1 and both output valid flags are 0.
- R2: `modSel` codes: 0 = BPSK, 1 = QPSK, 2 = 8-PSK, 3 = 16-QAM, 4 = 64-QAM, and 5..7 behave as BPSK. BPSK gives one soft bit from I, with index 0, on lane 0. Lane 1 is invalid in that cycle.
- R3: QPSK gives I (index 0) on lane 0 and Q (index 1) on lane 1 in a single cycle.
- R4: 8-PSK gives I and Q (indices 0, 1) in its first cycle. Its second cycle gives |I|−|Q| (index 2) on lane 0, with lane 1 invalid.
- R5: 16-QAM gives I and Q (indices 0, 1) in its first cycle and |I|−32 and |Q|−32 (indices 2, 3) in its second cycle.
- R6: 64-QAM takes three cycles. Cycle 1 gives I and 64−|I| (indices 0, 1). Cycle 2 gives 32−||I|−64| and Q (indices 2, 3). Cycle 3 gives 64−|Q| and 32−||Q|−64| (indices 4, 5).
- R7: Each output is floor((v·k + 8)/16), clipped to −32..31. Here v is the pre-scale value in sample LSBs and k is the unsigned 6-bit gain.
- R8: The first pair of a symbol appears on the second rising edge after acceptance. `symReady` is 0 during every emission cycle except the last one of a symbol, so symbols can be accepted back to back.
- R9: `modSel` is sampled only when a sample is accepted. A change while a symbol is being emitted does not alter that symbol's outputs.
- R10: The gain is sampled only at acceptance. A change during emission does not alter the running symbol's outputs.
- R11: Lane 1 is never valid without lane 0. When both are valid, lane 1's index is lane 0's index plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| symValid | input | 1 | Sample offered |
| symReady | output | 1 | Sample can be accepted this cycle |
| symI | input | 9 | In-phase component, signed, 16 LSB per unit |
| symQ | input | 9 | Quadrature component, signed |
| scaleK | input | 6 | Unsigned gain (2/σ², 4 fractional bits) |
| modSel | input | 3 | Modulation code |
| outValid0 | output | 1 | Lane 0 soft bit valid |
| llr0 | output | 6 | Lane 0 soft bit, signed |
| idx0 | output | 3 | Lane 0 bit index |
| outValid1 | output | 1 | Lane 1 soft bit valid |
| llr1 | output | 6 | Lane 1 soft bit, signed |
| idx1 | output | 3 | Lane 1 bit index |

## Verification
The hardest situation to reach from the ports is a modulation code or gain that changes while a multi-cycle 64-QAM symbol is still draining. A close second is a new symbol accepted in the very cycle that the previous one emits its last pair. The stimulus accepts a 64-QAM sample and then, with valid dropped, flips the code and the gain on the next falling edge, and probes ready on each of the following edges. Other runs keep valid high across a stream of mixed symbols, so acceptance lands exactly on the final emission cycle.

// File: rtl/llr_pkg.sv
package llr_pkg;

  typedef enum logic [2:0] {
    MOD_BPSK  = 3'd0,
    MOD_QPSK  = 3'd1,
    MOD_PSK8  = 3'd2,
    MOD_QAM16 = 3'd3,
    MOD_QAM64 = 3'd4
  } modType_e;

  typedef struct packed {
    logic     load;
    logic     emit;
    logic [1:0] phase;
    modType_e mod;
  } ctrlStrobe_t;

  function automatic modType_e decodeMod(logic [2:0] code);
    case (code)
      3'd1:    return MOD_QPSK;
      3'd2:    return MOD_PSK8;
      3'd3:    return MOD_QAM16;
      3'd4:    return MOD_QAM64;
      default: return MOD_BPSK;
    endcase
  endfunction

  function automatic logic [1:0] lastPhase(modType_e m);
    case (m)
      MOD_PSK8, MOD_QAM16: return 2'd1;
      MOD_QAM64:           return 2'd2;
      default:             return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/llr_ctrl.sv
module llr_ctrl
  import llr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        symValid,
  input  logic [2:0]  modSel,
  output logic        symReady,
  output ctrlStrobe_t strobe
);

  logic       busy;
  logic [1:0] phase;
  modType_e   modReg;
  logic       finalCycle;
  logic       load;

  assign finalCycle = (phase == lastPhase(modReg));
  assign symReady   = !busy || finalCycle;
  assign load       = symValid && symReady;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      phase  <= 2'd0;
      modReg <= MOD_BPSK;
    end else if (load) begin
      busy   <= 1'b1;
      phase  <= 2'd0;
      modReg <= decodeMod(modSel);
    end else if (busy) begin
      if (finalCycle) begin
        busy  <= 1'b0;
        phase <= 2'd0;
      end else begin
        phase <= phase + 2'd1;
      end
    end
  end

  always_comb begin
    strobe.load  = load;
    strobe.emit  = busy;
    strobe.phase = phase;
    strobe.mod   = modReg;
  end

  // R8: an accepted sample always starts an emission on the next cycle
  p_busy_after_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> busy);

  // R8: the phase counter never passes the last phase of the held modulation
  p_phase_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (phase <= lastPhase(modReg)));

  // R9: the held modulation only changes on an accepted sample
  p_mod_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !symValid) |=> $stable(modReg));

endmodule

// File: rtl/llr_lane.sv
module llr_lane #(
  parameter int PRE_W     = 12,
  parameter int SCALE_W   = 6,
  parameter int LLR_W     = 6,
  parameter int IDX_W     = 3,
  parameter int FRAC_BITS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    laneValid,
  input  logic signed [PRE_W-1:0] pre,
  input  logic [IDX_W-1:0]        idxIn,
  input  logic [SCALE_W-1:0]      scale,
  output logic                    outValid,
  output logic [LLR_W-1:0]        llrOut,
  output logic [IDX_W-1:0]        idxOut
);

  localparam int PROD_W  = PRE_W + SCALE_W + 1;
  localparam int LLR_MAX = (1 << (LLR_W - 1)) - 1;
  localparam int LLR_MIN = -(1 << (LLR_W - 1));
  localparam logic signed [PROD_W-1:0] MAXV  = PROD_W'(LLR_MAX);
  localparam logic signed [PROD_W-1:0] MINV  = PROD_W'(LLR_MIN);
  localparam logic signed [PROD_W-1:0] ROUND = PROD_W'(1 << (FRAC_BITS - 1));

  logic signed [PROD_W-1:0] prod;
  logic signed [PROD_W-1:0] rounded;
  logic [LLR_W-1:0]         clipped;

  always_comb begin
    prod    = PROD_W'(pre) * $signed({1'b0, scale});
    rounded = (prod + ROUND) >>> FRAC_BITS;
    if (rounded > MAXV)      clipped = LLR_W'(LLR_MAX);
    else if (rounded < MINV) clipped = LLR_W'(LLR_MIN);
    else                     clipped = rounded[LLR_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      llrOut   <= '0;
      idxOut   <= '0;
    end else begin
      outValid <= laneValid;
      if (laneValid) begin
        llrOut <= clipped;
        idxOut <= idxIn;
      end
    end
  end

  // R7: a non-negative pre-scale value never yields a negative soft bit
  p_sign_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (laneValid && pre >= 0) |=> !llrOut[LLR_W-1]);

endmodule

// File: rtl/llr_datapath.sv
module llr_datapath
  import llr_pkg::*;
#(
  parameter int SAMPLE_W  = 9,
  parameter int SCALE_W   = 6,
  parameter int LLR_W     = 6,
  parameter int IDX_W     = 3,
  parameter int FRAC_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  ctrlStrobe_t         strobe,
  input  logic [SAMPLE_W-1:0] symI,
  input  logic [SAMPLE_W-1:0] symQ,
  input  logic [SCALE_W-1:0]  scaleK,
  output logic                outValid0,
  output logic [LLR_W-1:0]    llr0,
  output logic [IDX_W-1:0]    idx0,
  output logic                outValid1,
  output logic [LLR_W-1:0]    llr1,
  output logic [IDX_W-1:0]    idx1
);

  localparam int LANES = 2;
  localparam int PRE_W = SAMPLE_W + 3;
  localparam int UNIT  = 1 << FRAC_BITS;
  localparam logic signed [PRE_W-1:0] TWO  = PRE_W'(2 * UNIT);
  localparam logic signed [PRE_W-1:0] FOUR = PRE_W'(4 * UNIT);

  logic [SAMPLE_W-1:0] sampI, sampQ;
  logic [SCALE_W-1:0]  scaleReg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sampI    <= '0;
      sampQ    <= '0;
      scaleReg <= '0;
    end else if (strobe.load) begin
      sampI    <= symI;
      sampQ    <= symQ;
      scaleReg <= scaleK;
    end
  end

  logic signed [PRE_W-1:0] xs, ys, absI, absQ, foldI, foldQ, offI, offQ;

  always_comb begin
    xs    = {{(PRE_W-SAMPLE_W){sampI[SAMPLE_W-1]}}, sampI};
    ys    = {{(PRE_W-SAMPLE_W){sampQ[SAMPLE_W-1]}}, sampQ};
    absI  = xs[PRE_W-1] ? -xs : xs;
    absQ  = ys[PRE_W-1] ? -ys : ys;
    offI  = absI - FOUR;
    offQ  = absQ - FOUR;
    foldI = offI[PRE_W-1] ? -offI : offI;
    foldQ = offQ[PRE_W-1] ? -offQ : offQ;
  end

  logic signed [PRE_W-1:0] preArr [LANES];
  logic                    selV   [LANES];
  logic [IDX_W-1:0]        selIdx [LANES];

  always_comb begin
    preArr[0] = xs;  preArr[1] = ys;
    selV[0]   = 1'b1; selV[1]  = 1'b0;
    selIdx[0] = IDX_W'(0); selIdx[1] = IDX_W'(1);
    case (strobe.mod)
      MOD_QPSK: selV[1] = 1'b1;
      MOD_PSK8: begin
        if (strobe.phase == 2'd0) begin
          selV[1] = 1'b1;
        end else begin
          preArr[0] = absI - absQ;
          selIdx[0] = IDX_W'(2);
        end
      end
      MOD_QAM16: begin
        selV[1] = 1'b1;
        if (strobe.phase != 2'd0) begin
          preArr[0] = absI - TWO;
          preArr[1] = absQ - TWO;
          selIdx[0] = IDX_W'(2);
          selIdx[1] = IDX_W'(3);
        end
      end
      MOD_QAM64: begin
        selV[1] = 1'b1;
        case (strobe.phase)
          2'd0: begin
            preArr[1] = FOUR - absI;
          end
          2'd1: begin
            preArr[0] = TWO - foldI;
            preArr[1] = ys;
            selIdx[0] = IDX_W'(2);
            selIdx[1] = IDX_W'(3);
          end
          default: begin
            preArr[0] = FOUR - absQ;
            preArr[1] = TWO - foldQ;
            selIdx[0] = IDX_W'(4);
            selIdx[1] = IDX_W'(5);
          end
        endcase
      end
      default: ;
    endcase
  end

  logic             laneOutV   [LANES];
  logic [LLR_W-1:0] laneOutLlr [LANES];
  logic [IDX_W-1:0] laneOutIdx [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    llr_lane #(
      .PRE_W(PRE_W), .SCALE_W(SCALE_W), .LLR_W(LLR_W),
      .IDX_W(IDX_W), .FRAC_BITS(FRAC_BITS)
    ) u_lane (
      .clk      (clk),
      .rst_n    (rst_n),
      .laneValid(strobe.emit && selV[g]),
      .pre      (preArr[g]),
      .idxIn    (selIdx[g]),
      .scale    (scaleReg),
      .outValid (laneOutV[g]),
      .llrOut   (laneOutLlr[g]),
      .idxOut   (laneOutIdx[g])
    );
  end

  assign outValid0 = laneOutV[0];
  assign llr0      = laneOutLlr[0];
  assign idx0      = laneOutIdx[0];
  assign outValid1 = laneOutV[1];
  assign llr1      = laneOutLlr[1];
  assign idx1      = laneOutIdx[1];

  // R11: lane 1 only accompanies lane 0 and carries the next bit index
  p_lane_pair_r11: assert property (@(posedge clk) disable iff (!rst_n)
    outValid1 |-> (outValid0 && idx1 == idx0 + IDX_W'(1)));

  // R2: a BPSK emission yields a single soft bit of index 0
  p_bpsk_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.emit && strobe.mod == MOD_BPSK) |=>
      (outValid0 && !outValid1 && idx0 == '0));

endmodule

// File: rtl/llr_demapper.sv
module llr_demapper
  import llr_pkg::*;
#(
  parameter int SAMPLE_W  = 9,
  parameter int SCALE_W   = 6,
  parameter int LLR_W     = 6,
  parameter int IDX_W     = 3,
  parameter int FRAC_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                symValid,
  output logic                symReady,
  input  logic [SAMPLE_W-1:0] symI,
  input  logic [SAMPLE_W-1:0] symQ,
  input  logic [SCALE_W-1:0]  scaleK,
  input  logic [2:0]          modSel,
  output logic                outValid0,
  output logic [LLR_W-1:0]    llr0,
  output logic [IDX_W-1:0]    idx0,
  output logic                outValid1,
  output logic [LLR_W-1:0]    llr1,
  output logic [IDX_W-1:0]    idx1
);

  ctrlStrobe_t strobe;

  llr_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .symValid(symValid),
    .modSel  (modSel),
    .symReady(symReady),
    .strobe  (strobe)
  );

  llr_datapath #(
    .SAMPLE_W(SAMPLE_W), .SCALE_W(SCALE_W), .LLR_W(LLR_W),
    .IDX_W(IDX_W), .FRAC_BITS(FRAC_BITS)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .symI     (symI),
    .symQ     (symQ),
    .scaleK   (scaleK),
    .outValid0(outValid0),
    .llr0     (llr0),
    .idx0     (idx0),
    .outValid1(outValid1),
    .llr1     (llr1),
    .idx1     (idx1)
  );

endmodule

// File: tb/llr_demapper_bench.sv
`timescale 1ns/1ps
module llr_demapper_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       symValid = 1'b0;
  logic       symReady;
  logic [8:0] symI = '0, symQ = '0;
  logic [5:0] scaleK = '0;
  logic [2:0] modSel = '0;
  logic       outValid0, outValid1;
  logic [5:0] llr0, llr1;
  logic [2:0] idx0, idx1;

  always #4 clk = ~clk;

  llr_demapper u_llr_demapper (
    .clk(clk), .rst_n(rst_n), .symValid(symValid), .symReady(symReady),
    .symI(symI), .symQ(symQ), .scaleK(scaleK), .modSel(modSel),
    .outValid0(outValid0), .llr0(llr0), .idx0(idx0),
    .outValid1(outValid1), .llr1(llr1), .idx1(idx1)
  );

  typedef struct {
    int    l0; int i0;
    bit    v1;
    int    l1; int i1;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int scaleSat(int pre, int k);
    int r;
    r = (pre * k + 8) >>> 4;
    if (r > 31) r = 31;
    if (r < -32) r = -32;
    return r;
  endfunction

  function automatic int iabs(int v);
    return v < 0 ? -v : v;
  endfunction

  task automatic pushSym(int code, int x, int y, int k, string tag);
    int pre[6];
    int n;
    int ax, ay;
    ax = iabs(x); ay = iabs(y);
    pre[0] = x; pre[1] = y;
    case (code)
      1: n = 2;
      2: begin n = 3; pre[2] = ax - ay; end
      3: begin n = 4; pre[2] = ax - 32; pre[3] = ay - 32; end
      4: begin
        n = 6;
        pre[1] = 64 - ax; pre[2] = 32 - iabs(ax - 64);
        pre[3] = y; pre[4] = 64 - ay; pre[5] = 32 - iabs(ay - 64);
      end
      default: n = 1;
    endcase
    for (int b = 0; b < n; b += 2) begin
      expItem_t it;
      it.l0 = scaleSat(pre[b], k); it.i0 = b;
      it.v1 = (b + 1 < n);
      it.l1 = it.v1 ? scaleSat(pre[b+1], k) : 0; it.i1 = b + 1;
      it.tag = tag;
      expQ.push_back(it);
    end
  endtask

  task automatic sendSym(int code, int x, int y, int k, string tag);
    @(negedge clk);
    symValid = 1'b1; modSel = 3'(code);
    symI = 9'(x); symQ = 9'(y); scaleK = 6'(k);
    pushSym(code, x, y, k, tag);
    while (!symReady) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic goIdle(int cycles);
    @(negedge clk);
    symValid = 1'b0;
    repeat (cycles) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (outValid1 && !outValid0)
        check(0, "R11", "lane1 valid alone", 1, 0);
      if (outValid0) begin
        if (expQ.size() == 0) begin
          check(0, "R8", "unexpected output", 1, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check($signed(llr0) == e.l0, e.tag, "llr0", $signed(llr0), e.l0);
          check(idx0 == e.i0, e.tag, "idx0", idx0, e.i0);
          check(outValid1 == e.v1, e.tag, "outValid1", outValid1, e.v1);
          if (e.v1) begin
            check($signed(llr1) == e.l1, e.tag, "llr1", $signed(llr1), e.l1);
            check(idx1 == e.i1, "R11", "idx1", idx1, e.i1);
          end
        end
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    check(0, "WATCHDOG", "timeout", 1, 0);
    finish();
  end

  initial begin
    repeat (3) @(negedge clk);
    check(symReady == 1'b1, "R1", "ready after reset", symReady, 1);
    check(outValid0 == 1'b0 && outValid1 == 1'b0, "R1", "valids after reset",
          outValid0 | outValid1, 0);
    rst_n = 1'b1;

    // R2 BPSK plus alias code
    sendSym(0, 16, 100, 16, "R2");
    sendSym(6, -40, 5, 10, "R2");
    goIdle(3);
    // R3 QPSK
    sendSym(1, 20, -35, 12, "R3");
    sendSym(1, -7, 9, 33, "R3");
    // R4 8-PSK
    sendSym(2, 50, -30, 8, "R4");
    sendSym(2, -10, 60, 9, "R4");
    // R5 16-QAM
    sendSym(3, 48, -16, 16, "R5");
    sendSym(3, -20, 40, 20, "R5");
    // R6 64-QAM
    sendSym(4, 80, -112, 8, "R6");
    sendSym(4, -24, 100, 6, "R6");
    goIdle(6);
    // R7 saturation and rounding
    sendSym(1, 255, -256, 63, "R7");
    sendSym(1, 1, -1, 8, "R7");
    sendSym(3, 0, 255, 0, "R7");
    goIdle(4);

    // R8 latency and ready, R9/R10 mid-symbol changes
    sendSym(4, 70, -90, 12, "R9");
    @(negedge clk);
    symValid = 1'b0; modSel = 3'd0; scaleK = 6'd1; symI = '0;
    check(outValid0 == 1'b0, "R8", "no output one edge after accept", outValid0, 0);
    check(symReady == 1'b0, "R8", "ready in first of three cycles", symReady, 0);
    @(negedge clk);
    check(symReady == 1'b0, "R8", "ready in second of three cycles", symReady, 0);
    @(negedge clk);
    check(symReady == 1'b1, "R8", "ready in final cycle", symReady, 1);
    goIdle(4);
    sendSym(3, 33, 66, 25, "R10");
    @(negedge clk);
    symValid = 1'b0; scaleK = 6'd63; modSel = 3'd4;
    goIdle(5);

    check(expQ.size() == 0, "R8", "pending expected items", expQ.size(), 0);
    finish();
  end

endmodule